// File: doc/BRIEF.md
# Parallel Logic-AND and Store Execute Unit

This block is the execute stage for one dual-operation instruction of a DSP core. A single 32-bit word carries two operations that run in the same clock cycle. The first ANDs a general register with a memory word fetched through an indirect address and writes the result back to a register. The second stores a general register to a second indirectly addressed location. Both operations read their sources from the state held at the start of the cycle, and every destination (registers, auxiliary registers, flags, memory) is committed on the closing clock edge.

The block holds eight 32-bit general registers, eight auxiliary address registers and two fixed index values. It computes two indirect addresses per cycle, each with optional post-modification of its auxiliary register. It drives a data-memory port that has a combinational read path and a write that the memory commits on the clock edge. A flag register is updated when the AND result lands in a general register.

Top module: `andstore_exec`

## Requirements
- R1: The word is accepted only when `instrValid` is 1, bits 31:26 equal 6'b110100, and bit 3 of both indirect fields is 0. Bit 25 selects the destination bank (0 = general register, 1 = auxiliary register). Bits 24:22 hold the AND destination, 21:19 the AND register source and 18:16 the store source. Bits 15:8 hold the store indirect field and bits 7:0 the AND indirect field. A word that is not accepted changes no state and keeps `memWrEn` at 0.
- R2: In an indirect field, bit 7 is post-modify, bit 6 is subtract and bits 5:4 choose the displacement (0, 1, IR0 = 4, IR1 = 8). Bits 2:0 pick the auxiliary register. With post-modify 0, the address is ARn ± displacement, computed modulo 2^AW. After reset, ARn holds 16·n.
- R3: With post-modify 1, the address is ARn as it stood at the start of the cycle, and ARn ± displacement is written to ARn at the end of the cycle.
- R4: The result of `Rsrc1 AND mem[src2 address]` is written to the general register named by the destination field at the end of the cycle.
- R5: The store writes the value its source register held at the start of the cycle, even when the same instruction's AND writes that register.
- R6: When the two indirect addresses are equal, the AND uses the memory word as it was before the store of the same cycle.
- R7: With a general-register destination, `flags` updates as follows: N (bit 3) takes the result MSB, Z (bit 2) is set when the result is zero, and V (bit 1) and UF (bit 4) are cleared.
- R8: With an auxiliary-register destination, the low AW result bits go to that auxiliary register and no flag changes. This write takes precedence over a post-modify of the same register.
- R9: Reset loads the flags with 7'h61 (LUF bit 6, LV bit 5 and C bit 0 set) and all general registers with all ones. LUF, LV and C never change afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| instrValid | input | 1 | Instruction word present this cycle |
| instr | input | 32 | Instruction word |
| memRdAddr | output | AW | Address of the AND memory operand |
| memRdData | input | DW | Memory word at memRdAddr (same cycle) |
| memWrEn | output | 1 | Store strobe, committed by memory at the clock edge |
| memWrAddr | output | AW | Store address |
| memWrData | output | DW | Store data |
| flags | output | 7 | {LUF, LV, UF, N, Z, V, C} |

## Verification
Register writeback by the AND and register read by the store land in the same cycle when the store source equals the AND destination. So do the memory read and the memory write when both indirect fields resolve to one address. The bench provokes the first by storing R1 while the AND rewrites R1, and judges it by the store data equal to the old value. It provokes the second with two different modes that point at one word. It judges that case by a later store of the AND destination showing the pre-store memory word, while memory itself holds the stored value. A third collision, an auxiliary-register result and a post-modify of the same register, is judged by the address the next instruction drives.

// File: rtl/andstore_pkg.sv
package andstore_pkg;

  localparam logic [5:0] OPC_ANDST = 6'b110100;

  // flag bit positions
  localparam int FC   = 0;
  localparam int FV   = 1;
  localparam int FZ   = 2;
  localparam int FN   = 3;
  localparam int FUF  = 4;
  localparam int FLV  = 5;
  localparam int FLUF = 6;

  typedef struct packed {
    logic       post;
    logic       sub;
    logic [1:0] disp;
    logic       rsvd;
    logic [2:0] ar;
  } indField_t;

  typedef struct packed {
    logic [5:0] op;
    logic       arDst;
    logic [2:0] dst1;
    logic [2:0] src1;
    logic [2:0] src3;
    indField_t  dst2;
    indField_t  src2;
  } instrWord_t;

  typedef struct packed {
    logic       post;
    logic       sub;
    logic [1:0] disp;
    logic [2:0] ar;
  } indDec_t;

  typedef struct packed {
    logic [2:0] dst1;
    logic [2:0] src1;
    logic [2:0] src3;
    indDec_t    dst2;
    indDec_t    src2;
  } decFields_t;

  typedef struct packed {
    logic regWr;
    logic arWr;
    logic flagWr;
    logic storeEn;
    logic srcPost;
    logic dstPost;
  } ctrlStrobes_t;

endpackage

// File: rtl/andstore_agu.sv
module andstore_agu #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] arVal,
  input  logic          sub,
  input  logic          post,
  input  logic [1:0]    dispSel,
  input  logic [AW-1:0] ir0,
  input  logic [AW-1:0] ir1,
  output logic [AW-1:0] addr,
  output logic [AW-1:0] nextAr
);
  logic [AW-1:0] disp;

  always_comb begin
    unique case (dispSel)
      2'd0:    disp = '0;
      2'd1:    disp = AW'(1);
      2'd2:    disp = ir0;
      default: disp = ir1;
    endcase
    nextAr = sub ? (arVal - disp) : (arVal + disp);
    addr   = post ? arVal : nextAr;
  end
endmodule

// File: rtl/andstore_ctrl.sv
module andstore_ctrl
  import andstore_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         instrValid,
  input  logic [31:0]  instr,
  output ctrlStrobes_t ctrl,
  output decFields_t   dec
);
  instrWord_t word;
  logic       hit;

  assign word = instrWord_t'(instr);
  assign hit  = instrValid && (word.op == OPC_ANDST)
                && !word.src2.rsvd && !word.dst2.rsvd;

  always_comb begin
    dec.dst1 = word.dst1;
    dec.src1 = word.src1;
    dec.src3 = word.src3;
    dec.dst2 = '{post: word.dst2.post, sub: word.dst2.sub,
                 disp: word.dst2.disp, ar: word.dst2.ar};
    dec.src2 = '{post: word.src2.post, sub: word.src2.sub,
                 disp: word.src2.disp, ar: word.src2.ar};

    ctrl.regWr   = hit && !word.arDst;
    ctrl.arWr    = hit &&  word.arDst;
    ctrl.flagWr  = hit && !word.arDst;
    ctrl.storeEn = hit;
    ctrl.srcPost = hit && word.src2.post;
    ctrl.dstPost = hit && word.dst2.post;
  end

  // R1: nothing fires without a valid word
  assert_valid_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !instrValid |-> !(ctrl.storeEn || ctrl.regWr || ctrl.arWr || ctrl.srcPost || ctrl.dstPost));

  // R8: exactly one destination bank per accepted word
  assert_one_bank_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctrl.regWr, ctrl.arWr}));
endmodule

// File: rtl/andstore_dpath.sv
module andstore_dpath
  import andstore_pkg::*;
#(
  parameter int          DW         = 32,
  parameter int          AW         = 16,
  parameter int          NREG       = 8,
  parameter int          AR_STEP    = 16,
  parameter int          IR0_VAL    = 4,
  parameter int          IR1_VAL    = 8,
  parameter logic [31:0] REG_RESET  = 32'hFFFF_FFFF,
  parameter logic [6:0]  FLAG_RESET = 7'h61
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ctrlStrobes_t  ctrl,
  input  decFields_t    dec,
  output logic [AW-1:0] memRdAddr,
  input  logic [DW-1:0] memRdData,
  output logic          memWrEn,
  output logic [AW-1:0] memWrAddr,
  output logic [DW-1:0] memWrData,
  output logic [6:0]    flags
);
  localparam int NPORT = 2;

  logic [NREG-1:0][DW-1:0] regFile;
  logic [NREG-1:0][AW-1:0] arFile;
  logic [6:0]              flagReg;
  logic [DW-1:0]           andRes;

  indDec_t       fld    [NPORT];
  logic [AW-1:0] addr   [NPORT];
  logic [AW-1:0] nextAr [NPORT];

  assign fld[0] = dec.src2;
  assign fld[1] = dec.dst2;

  for (genvar g = 0; g < NPORT; g++) begin : gAgu
    andstore_agu #(.AW(AW)) uAgu (
      .arVal   (arFile[fld[g].ar]),
      .sub     (fld[g].sub),
      .post    (fld[g].post),
      .dispSel (fld[g].disp),
      .ir0     (AW'(IR0_VAL)),
      .ir1     (AW'(IR1_VAL)),
      .addr    (addr[g]),
      .nextAr  (nextAr[g])
    );
  end

  assign memRdAddr = addr[0];
  assign memWrAddr = addr[1];
  assign memWrEn   = ctrl.storeEn;
  assign memWrData = regFile[dec.src3];
  assign andRes    = regFile[dec.src1] & memRdData;
  assign flags     = flagReg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) begin
        regFile[i] <= DW'(REG_RESET);
        arFile[i]  <= AW'(i * AR_STEP);
      end
      flagReg <= FLAG_RESET;
    end else begin
      if (ctrl.regWr) regFile[dec.dst1] <= andRes;
      for (int i = 0; i < NREG; i++) begin
        if (ctrl.arWr && dec.dst1 == i[2:0])
          arFile[i] <= andRes[AW-1:0];
        else if (ctrl.dstPost && dec.dst2.ar == i[2:0])
          arFile[i] <= nextAr[1];
        else if (ctrl.srcPost && dec.src2.ar == i[2:0])
          arFile[i] <= nextAr[0];
      end
      if (ctrl.flagWr) begin
        flagReg[FN]  <= andRes[DW-1];
        flagReg[FZ]  <= (andRes == '0);
        flagReg[FV]  <= 1'b0;
        flagReg[FUF] <= 1'b0;
      end
    end
  end

  // R4: AND result lands in the named register one edge later
  assert_writeback_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.regWr |=> regFile[$past(dec.dst1)] == $past(andRes));

  // R7: flag values after a general-register destination
  assert_flag_update_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.flagWr |=> (flagReg[FN] == $past(andRes[DW-1])) && (flagReg[FZ] == ($past(andRes) == '0))
                    && !flagReg[FV] && !flagReg[FUF]);

  // R8: no flag update means flags hold
  assert_flag_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.flagWr |=> $stable(flagReg));

  // R8: auxiliary-register result wins over post-modify
  assert_ar_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.arWr |=> arFile[$past(dec.dst1)] == $past(andRes[AW-1:0]));

  // R9: sticky flags never move
  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable({flagReg[FLUF], flagReg[FLV], flagReg[FC]}));

  // R1: a rejected word leaves the register files alone
  assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.storeEn |=> $stable(regFile) && $stable(arFile));
endmodule

// File: rtl/andstore_exec.sv
module andstore_exec
  import andstore_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          instrValid,
  input  logic [31:0]   instr,
  output logic [AW-1:0] memRdAddr,
  input  logic [DW-1:0] memRdData,
  output logic          memWrEn,
  output logic [AW-1:0] memWrAddr,
  output logic [DW-1:0] memWrData,
  output logic [6:0]    flags
);
  ctrlStrobes_t ctrl;
  decFields_t   dec;

  andstore_ctrl uCtrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .instrValid (instrValid),
    .instr      (instr),
    .ctrl       (ctrl),
    .dec        (dec)
  );

  andstore_dpath #(.DW(DW), .AW(AW)) uDpath (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl      (ctrl),
    .dec       (dec),
    .memRdAddr (memRdAddr),
    .memRdData (memRdData),
    .memWrEn   (memWrEn),
    .memWrAddr (memWrAddr),
    .memWrData (memWrData),
    .flags     (flags)
  );
endmodule

// File: tb/sim_andstore_exec.sv
`timescale 1ns/1ps
module sim_andstore_exec;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instrValid = 1'b0;
  logic [31:0] instr = '0;
  logic [15:0] memRdAddr, memWrAddr;
  logic [31:0] memRdData, memWrData;
  logic        memWrEn;
  logic [6:0]  flags;
  logic [31:0] mem [256];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  andstore_exec u0 (
    .clk(clk), .rst_n(rst_n), .instrValid(instrValid), .instr(instr),
    .memRdAddr(memRdAddr), .memRdData(memRdData), .memWrEn(memWrEn),
    .memWrAddr(memWrAddr), .memWrData(memWrData), .flags(flags)
  );

  assign memRdData = mem[memRdAddr[7:0]];
  always @(posedge clk) if (memWrEn) mem[memWrAddr[7:0]] <= memWrData;

  function automatic logic [7:0] ind(bit post, bit sub, logic [1:0] disp, logic [2:0] ar);
    return {post, sub, disp, 1'b0, ar};
  endfunction

  function automatic logic [31:0] enc(bit ext, logic [2:0] d1, logic [2:0] s1,
                                      logic [2:0] s3, logic [7:0] d2, logic [7:0] s2);
    return {6'b110100, ext, d1, s1, s3, d2, s2};
  endfunction

  typedef struct packed {
    logic [31:0] ins;
    logic [15:0] rd;
    logic [15:0] wa;
    logic [31:0] wd;
    logic [6:0]  fl;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{enc(0,1,2,3, ind(0,0,1,2), ind(0,0,0,1)), 16'd16,  16'd33,  32'hFFFF_FFFF, 7'h61}, // R4 R2
    '{enc(0,1,4,1, ind(0,0,1,5), ind(0,0,0,0)), 16'd0,   16'd81,  32'h0F0F_0010, 7'h61}, // R5
    '{enc(0,7,0,1, ind(0,0,0,6), ind(0,0,0,4)), 16'd64,  16'd96,  32'h0F0F_0000, 7'h65}, // R7 zero
    '{enc(0,6,5,7, ind(0,1,2,7), ind(0,0,1,2)), 16'd33,  16'd108, 32'h0000_0000, 7'h69}, // R7 neg, R2 sub
    '{enc(0,2,6,6, ind(0,1,0,5), ind(0,0,0,5)), 16'd80,  16'd80,  32'hFFFF_FFFF, 7'h61}, // R6
    '{enc(0,3,2,2, ind(1,0,1,0), ind(0,0,0,5)), 16'd80,  16'd0,   32'h0F0F_0050, 7'h61}, // R6 R3
    '{enc(0,0,4,3, ind(1,1,2,7), ind(0,0,0,0)), 16'd1,   16'd112, 32'h0F0F_0050, 7'h61}, // R3
    '{enc(1,3,5,0, ind(0,0,0,7), ind(0,0,1,2)), 16'd33,  16'd108, 32'h0F0F_0001, 7'h61}, // R8 R3
    '{enc(0,5,6,0, ind(0,0,2,3), ind(0,0,1,3)), 16'd0,   16'd3,   32'h0F0F_0001, 7'h61}, // R8 R2 wrap
    '{enc(1,4,6,0, ind(1,0,1,4), ind(0,0,0,0)), 16'd1,   16'd64,  32'h0F0F_0001, 7'h61}, // R8 priority
    '{enc(0,1,6,0, ind(0,0,0,4), ind(0,0,0,4)), 16'd1,   16'd1,   32'h0F0F_0001, 7'h61}  // R8 R9
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int a = 0; a < 256; a++) mem[a] = 32'h0F0F_0000 + a;
    mem[64] = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk("R9 reset flags", {25'd0, flags}, 32'h61);
    chk("R1 idle store strobe", {31'd0, memWrEn}, 32'd0);

    // R1: invalid word with post-modify and a zero result, valid low
    instr = enc(0,1,2,3, ind(1,0,1,0), ind(1,0,1,4));
    instrValid = 1'b0;
    #1 chk("R1 valid-low store strobe", {31'd0, memWrEn}, 32'd0);
    @(posedge clk); #1;
    chk("R1 valid-low flags", {25'd0, flags}, 32'h61);

    // R1: wrong opcode, would give Z
    @(negedge clk);
    instr = enc(0,1,2,3, ind(1,0,1,0), ind(1,0,0,4)) ^ 32'h8000_0000;
    instrValid = 1'b1;
    #1 chk("R1 bad-opcode store strobe", {31'd0, memWrEn}, 32'd0);
    @(posedge clk); #1;
    chk("R1 bad-opcode flags", {25'd0, flags}, 32'h61);

    // R1: reserved bit set
    @(negedge clk);
    instr = enc(0,1,2,3, ind(1,0,1,0), ind(1,0,0,4)) | 32'h0000_0008;
    #1 chk("R1 reserved-bit store strobe", {31'd0, memWrEn}, 32'd0);
    @(posedge clk); #1;
    chk("R1 reserved-bit flags", {25'd0, flags}, 32'h61);

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      instr = VECS[v].ins;
      instrValid = 1'b1;
      #1;
      chk($sformatf("R2 vec%0d read address", v), {16'd0, memRdAddr}, {16'd0, VECS[v].rd});
      chk($sformatf("R1 vec%0d store strobe", v), {31'd0, memWrEn}, 32'd1);
      chk($sformatf("R3 vec%0d store address", v), {16'd0, memWrAddr}, {16'd0, VECS[v].wa});
      chk($sformatf("R5 vec%0d store data", v), memWrData, VECS[v].wd);
      @(posedge clk); #1;
      chk($sformatf("R7 vec%0d flags", v), {25'd0, flags}, {25'd0, VECS[v].fl});
      if (v == 4) chk("R6 stored word in memory", mem[80], 32'hFFFF_FFFF);
    end

    @(negedge clk);
    instrValid = 1'b0;
    #1 chk("R1 final idle strobe", {31'd0, memWrEn}, 32'd0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule